// File: doc/BRIEF.md
# DMA Command Injection and Interrupt Register Unit

This block is the register-facing front end of a multi-channel DMA engine. Software stages an instruction in two registers: a channel selector and an opcode byte in the first, a 32-bit operand in the second. A write of zero to a separate launch register then sends the staged instruction to the channel engines as a single strobe. The strobe carries the zero-based channel index, the opcode (0xA0 starts a channel, 0x01 kills one) and the operand, which is the program start address for a start. A busy flag stays high from the launch until the target channel has taken the command. Software polls this flag before it launches again.

The same unit gathers one completion event per channel into a sticky pending vector. It masks that vector with a per-channel enable register and drives one interrupt line. Software clears a pending bit by writing a one to it. The register port also shows each channel's 4-bit state code and its program counter. State codes: 0 stopped, 1 executing, 2 cache miss, 3 PC update, 4 waiting for event, 5 barrier, 6 queue busy, 7 waiting for peripheral, 8 killing, 9 completing, 0xE fault completing, 0xF faulting.

Top module: `dma_dbg_irq_unit`

## Requirements
- R1: After synchronous reset, `busy`, `irq` and `cmd_valid` are 0, and the enable (0x020) and pending (0x024) registers read 0.
- R2: Writes to 0xD08 (selector in bits 15:8, opcode in bits 23:16) and to 0xD0C (operand) are stored and read back unchanged.
- R3: A write of value 0 to 0xD04 with selector S, where 1 <= S <= NUM_CH, raises `cmd_valid` and `busy` at the next clock edge. It drives `cmd_chan` = S-1, `cmd_opcode` = bits 23:16 of 0xD08 and `cmd_operand` = the value in 0xD0C.
- R4: `cmd_valid` and its fields stay unchanged until a cycle with `cmd_ack` high. `cmd_valid` falls at that edge, and `busy` falls one edge later.
- R5: A write to 0xD04 is ignored when the selector is 0, when the selector is above NUM_CH, when the written value is nonzero, or while `busy` is high. An ignored write raises neither `cmd_valid` nor `busy` and does not alter a command already issued.
- R6: Bit 0 of 0xD00 reads the busy flag. All other bits read 0.
- R7: A high `ch_event[n]` sets bit n of the pending register (0x024). That bit stays set until it is cleared. 0x020 holds the enables, and 0x028 reads pending AND enable.
- R8: Writing a 1 to bit n of 0x02C clears pending bit n. Bits written 0 are untouched. An event in the same cycle as the clear leaves the bit set.
- R9: `irq` is the OR over all channels of pending AND enable, registered. It reflects a register write or an event at the edge that updates those registers.
- R10: Address 0x100+8n reads channel n's state code in bits 3:0 with zeros above. Address 0x104+8n reads channel n's program counter.
- R11: Read data appears on `rdata` one cycle after `rd_en`. Addresses that are not mapped, including channel slots at or beyond NUM_CH, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| busy | output | 1 | Injected command not yet fully accepted |
| cmd_valid | output | 1 | Command strobe toward the channel engines |
| cmd_chan | output | CHW | Target channel index |
| cmd_opcode | output | 8 | First instruction byte |
| cmd_operand | output | 32 | Remaining four instruction bytes |
| cmd_ack | input | 1 | Target channel accepts the command |
| ch_event | input | NUM_CH | Per-channel completion events |
| ch_state | input | 4*NUM_CH | Per-channel state codes, channel n in bits 4n+3:4n |
| ch_pc | input | 32*NUM_CH | Per-channel program counters, channel n in bits 32n+31:32n |
| irq | output | 1 | Combined interrupt |

## Verification
The bench launches commands at selector 1, at selector NUM_CH, and at the illegal values 0, NUM_CH+1 and 255. A design with an off-by-one in the range check would strobe a channel that does not exist, or would ignore the last real one. It also launches a second time while the first command is still pending, and issues a launch with a nonzero value. A design without the busy guard would overwrite the channel and operand of a command already in flight. The bench checks that busy stays high for exactly one cycle after the acknowledge, because software polls it. It clears a pending bit in the same cycle that a new event arrives, and here a design that lets the clear win would drop that interrupt.

// File: rtl/dma_dbg_pkg.sv
package dma_dbg_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_IRQ_EN   = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_IRQ_RAW  = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_IRQ_MSK  = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_IRQ_CLR  = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_CH_BASE  = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_DBG_STAT = 12'hD00;
  localparam logic [ADDR_W-1:0] OFS_DBG_CMD  = 12'hD04;
  localparam logic [ADDR_W-1:0] OFS_DBG_I0   = 12'hD08;
  localparam logic [ADDR_W-1:0] OFS_DBG_I1   = 12'hD0C;

  typedef struct packed {
    logic [7:0]        opcode;
    logic [DATA_W-1:0] operand;
  } cmd_payload_t;
endpackage

// File: rtl/dma_dbg_cmd.sv
module dma_dbg_cmd
  import dma_dbg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cmd_ack,
  output logic [DATA_W-1:0] inst0_q,
  output logic [DATA_W-1:0] inst1_q,
  output logic              busy,
  output logic              cmd_valid,
  output logic [CHW-1:0]    cmd_chan,
  output cmd_payload_t      cmd_pay
);
  logic [7:0] sel;
  logic       sel_ok;
  logic       launch;
  logic       ack_seen;

  assign sel    = inst0_q[15:8];
  assign sel_ok = (sel != 8'd0) && (32'(sel) <= 32'(NUM_CH));
  assign launch = wr_en && (addr == OFS_DBG_CMD) && (wdata == '0) && !busy && sel_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      inst0_q   <= '0;
      inst1_q   <= '0;
      busy      <= 1'b0;
      cmd_valid <= 1'b0;
      ack_seen  <= 1'b0;
      cmd_chan  <= '0;
      cmd_pay   <= '0;
    end else begin
      if (wr_en && addr == OFS_DBG_I0) inst0_q <= wdata;
      if (wr_en && addr == OFS_DBG_I1) inst1_q <= wdata;
      if (launch) begin
        busy            <= 1'b1;
        cmd_valid       <= 1'b1;
        cmd_chan        <= CHW'(sel - 8'd1);
        cmd_pay.opcode  <= inst0_q[23:16];
        cmd_pay.operand <= inst1_q;
      end else if (cmd_valid && cmd_ack) begin
        cmd_valid <= 1'b0;
        ack_seen  <= 1'b1;
      end else if (ack_seen) begin
        ack_seen <= 1'b0;
        busy     <= 1'b0;
      end
    end
  end

  assert_launch_from_write_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en && addr == OFS_DBG_CMD && wdata == '0));
  assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_chan) && $stable(cmd_pay)));
  assert_busy_release_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ack) |=> (busy && !cmd_valid) ##1 !busy);
  assert_strobe_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy);
  assert_chan_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (32'(cmd_chan) < 32'(NUM_CH)));
endmodule

// File: rtl/dma_dbg_irq.sv
module dma_dbg_irq
  import dma_dbg_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] ch_event,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] raw_q,
  output logic              irq
);
  logic [NUM_CH-1:0] en_d, clr_mask, raw_d;

  always_comb begin
    en_d     = (wr_en && addr == OFS_IRQ_EN)  ? wdata[NUM_CH-1:0] : en_q;
    clr_mask = (wr_en && addr == OFS_IRQ_CLR) ? wdata[NUM_CH-1:0] : '0;
    raw_d    = (raw_q & ~clr_mask) | ch_event;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      raw_q <= '0;
      irq   <= 1'b0;
    end else begin
      en_q  <= en_d;
      raw_q <= raw_d;
      irq   <= |(raw_d & en_d);
    end
  end

  assert_event_sticks_R7: assert property (@(posedge clk) disable iff (rst)
    (|ch_event) |=> ((raw_q & $past(ch_event)) == $past(ch_event)));
  assert_clear_works_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_IRQ_CLR) |=>
      ((raw_q & $past(wdata[NUM_CH-1:0]) & ~$past(ch_event)) == '0));
  assert_irq_needs_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|(raw_q & en_q)));
endmodule

// File: rtl/dma_dbg_rdmux.sv
module dma_dbg_rdmux
  import dma_dbg_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   busy,
  input  logic [DATA_W-1:0]      inst0_q,
  input  logic [DATA_W-1:0]      inst1_q,
  input  logic [NUM_CH-1:0]      en_q,
  input  logic [NUM_CH-1:0]      raw_q,
  input  logic [4*NUM_CH-1:0]    ch_state,
  input  logic [32*NUM_CH-1:0]   ch_pc,
  output logic [DATA_W-1:0]      rdata
);
  logic [3:0]        st_arr [NUM_CH];
  logic [31:0]       pc_arr [NUM_CH];
  logic [ADDR_W-1:0] off;
  logic              in_ch;
  logic [DATA_W-1:0] rd_d;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign st_arr[g] = ch_state[4*g +: 4];
    assign pc_arr[g] = ch_pc[32*g +: 32];
  end

  assign off   = addr - OFS_CH_BASE;
  assign in_ch = (addr >= OFS_CH_BASE) && (32'(off[ADDR_W-1:3]) < 32'(NUM_CH));

  always_comb begin
    rd_d = '0;
    case (addr)
      OFS_IRQ_EN:   rd_d = DATA_W'(en_q);
      OFS_IRQ_RAW:  rd_d = DATA_W'(raw_q);
      OFS_IRQ_MSK:  rd_d = DATA_W'(raw_q & en_q);
      OFS_DBG_STAT: rd_d = DATA_W'(busy);
      OFS_DBG_I0:   rd_d = inst0_q;
      OFS_DBG_I1:   rd_d = inst1_q;
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (in_ch && 32'(off[ADDR_W-1:3]) == i)
            rd_d = off[2] ? pc_arr[i] : DATA_W'(st_arr[i]);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_d;
  end
endmodule

// File: rtl/dma_dbg_irq_unit.sv
module dma_dbg_irq_unit
  import dma_dbg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [11:0]          addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 busy,
  output logic                 cmd_valid,
  output logic [CHW-1:0]       cmd_chan,
  output logic [7:0]           cmd_opcode,
  output logic [31:0]          cmd_operand,
  input  logic                 cmd_ack,
  input  logic [NUM_CH-1:0]    ch_event,
  input  logic [4*NUM_CH-1:0]  ch_state,
  input  logic [32*NUM_CH-1:0] ch_pc,
  output logic                 irq
);
  logic [DATA_W-1:0] inst0_q, inst1_q;
  logic [NUM_CH-1:0] en_q, raw_q;
  cmd_payload_t      cmd_pay;

  dma_dbg_cmd #(.NUM_CH(NUM_CH), .CHW(CHW)) u_cmd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cmd_ack(cmd_ack), .inst0_q(inst0_q), .inst1_q(inst1_q), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_pay(cmd_pay)
  );

  assign cmd_opcode  = cmd_pay.opcode;
  assign cmd_operand = cmd_pay.operand;

  dma_dbg_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ch_event(ch_event), .en_q(en_q), .raw_q(raw_q), .irq(irq)
  );

  dma_dbg_rdmux #(.NUM_CH(NUM_CH)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .busy(busy),
    .inst0_q(inst0_q), .inst1_q(inst1_q), .en_q(en_q), .raw_q(raw_q),
    .ch_state(ch_state), .ch_pc(ch_pc), .rdata(rdata)
  );
endmodule

// File: tb/dma_dbg_irq_unit_bench.sv
`timescale 1ns/1ps
module dma_dbg_irq_unit_bench;
  localparam int NUM_CH = 8;
  localparam int CHW    = 3;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]          addr = '0;
  logic [31:0]          wdata = '0;
  logic [31:0]          rdata;
  logic                 busy, cmd_valid, irq;
  logic [CHW-1:0]       cmd_chan;
  logic [7:0]           cmd_opcode;
  logic [31:0]          cmd_operand;
  logic                 cmd_ack = 1'b0;
  logic [NUM_CH-1:0]    ch_event = '0;
  logic [4*NUM_CH-1:0]  ch_state = '0;
  logic [32*NUM_CH-1:0] ch_pc = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_dbg_irq_unit #(.NUM_CH(NUM_CH)) u_dma_dbg_irq_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_chan(cmd_chan), .cmd_opcode(cmd_opcode), .cmd_operand(cmd_operand),
    .cmd_ack(cmd_ack), .ch_event(ch_event), .ch_state(ch_state),
    .ch_pc(ch_pc), .irq(irq)
  );

  // {launch expected, selector, opcode, operand}
  localparam logic [48:0] VEC [6] = '{
    {1'b1, 8'd1,   8'hA0, 32'h0000_1000},
    {1'b1, 8'd8,   8'h01, 32'h0000_0000},
    {1'b0, 8'd0,   8'hA0, 32'hDEAD_0000},
    {1'b0, 8'd9,   8'hA0, 32'hDEAD_0001},
    {1'b1, 8'd4,   8'hA0, 32'h8000_0040},
    {1'b0, 8'd255, 8'h01, 32'hDEAD_0002}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic ack_and_release(input string req);
    cmd_ack = 1'b1;
    @(negedge clk);
    cmd_ack = 1'b0;
    check({req, " strobe drops on ack"}, 32'(cmd_valid), 32'd0);
    check({req, " busy one cycle past ack"}, 32'(busy), 32'd1);
    @(negedge clk);
    check({req, " busy released"}, 32'(busy), 32'd0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 cmd_valid", 32'(cmd_valid), 32'd0);
    rd(12'h020, d); check("R1 enable reg", d, 32'd0);
    rd(12'h024, d); check("R1 pending reg", d, 32'd0);

    // Vector table: R3 launches, R5 illegal selectors
    for (int i = 0; i < 6; i++) begin
      logic        exp_l;
      logic [7:0]  s, op;
      logic [31:0] opd;
      {exp_l, s, op, opd} = VEC[i];
      wr(12'hD08, {8'h00, op, s, 8'h00});
      wr(12'hD0C, opd);
      wr(12'hD04, 32'd0);
      check("R3/R5 strobe after launch", 32'(cmd_valid), 32'(exp_l));
      check("R3/R5 busy after launch", 32'(busy), 32'(exp_l));
      if (exp_l) begin
        check("R3 channel index", 32'(cmd_chan), 32'(s - 8'd1));
        check("R3 opcode", 32'(cmd_opcode), 32'(op));
        check("R3 operand", cmd_operand, opd);
        rd(12'hD00, d); check("R6 status busy bit", d, 32'd1);
        check("R4 strobe held", 32'(cmd_valid), 32'd1);
        check("R4 channel held", 32'(cmd_chan), 32'(s - 8'd1));
        ack_and_release("R4");
        rd(12'hD00, d); check("R6 status idle", d, 32'd0);
      end
    end

    // R2 staging readback
    wr(12'hD08, 32'h00A0_0300);
    wr(12'hD0C, 32'h1234_ABCD);
    rd(12'hD08, d); check("R2 inst0 readback", d, 32'h00A0_0300);
    rd(12'hD0C, d); check("R2 inst1 readback", d, 32'h1234_ABCD);

    // R5 nonzero launch value ignored
    wr(12'hD04, 32'd1);
    check("R5 nonzero launch value", 32'(cmd_valid), 32'd0);
    check("R5 nonzero launch busy", 32'(busy), 32'd0);

    // R5 launch while busy ignored
    wr(12'hD04, 32'd0);
    check("R5 first launch", 32'(cmd_chan), 32'd2);
    wr(12'hD08, 32'h0001_0600);
    wr(12'hD0C, 32'h0000_0000);
    wr(12'hD04, 32'd0);
    check("R5 busy launch keeps chan", 32'(cmd_chan), 32'd2);
    check("R5 busy launch keeps opcode", 32'(cmd_opcode), 32'hA0);
    check("R5 busy launch keeps operand", cmd_operand, 32'h1234_ABCD);
    ack_and_release("R5");
    @(negedge clk);
    check("R5 no late second strobe", 32'(cmd_valid), 32'd0);

    // R7 / R9 pending, enable, mask
    ch_event = 8'h04;
    @(negedge clk);
    ch_event = '0;
    check("R9 irq masked off", 32'(irq), 32'd0);
    rd(12'h024, d); check("R7 pending latched", d, 32'h04);
    rd(12'h028, d); check("R7 masked zero", d, 32'h00);
    wr(12'h020, 32'h04);
    check("R9 irq on enable", 32'(irq), 32'd1);
    rd(12'h020, d); check("R7 enable readback", d, 32'h04);
    rd(12'h028, d); check("R7 masked", d, 32'h04);

    // R8 clear racing a new event
    wr_en = 1'b1; addr = 12'h02C; wdata = 32'h04; ch_event = 8'h04;
    @(negedge clk);
    wr_en = 1'b0; ch_event = '0;
    rd(12'h024, d); check("R8 event beats clear", d, 32'h04);
    check("R9 irq stays", 32'(irq), 32'd1);
    ch_event = 8'h20;
    @(negedge clk);
    ch_event = '0;
    wr(12'h02C, 32'h20);
    rd(12'h024, d); check("R8 clear leaves other bits", d, 32'h04);
    wr(12'h02C, 32'h04);
    check("R9 irq drops after clear", 32'(irq), 32'd0);
    rd(12'h024, d); check("R8 cleared", d, 32'h00);

    // R10 channel status and pc
    ch_state[3*4 +: 4]  = 4'h9;
    ch_pc[3*32 +: 32]   = 32'h1234_5678;
    ch_state[7*4 +: 4]  = 4'hF;
    rd(12'h118, d); check("R10 ch3 state", d, 32'h9);
    rd(12'h11C, d); check("R10 ch3 pc", d, 32'h1234_5678);
    rd(12'h138, d); check("R10 ch7 state", d, 32'hF);

    // R11 unmapped reads
    rd(12'h140, d); check("R11 slot past last channel", d, 32'h0);
    rd(12'h500, d); check("R11 unmapped", d, 32'h0);

    finish_run();
  end
endmodule